// File: doc/BRIEF.md
# Synchronous Character Alignment Detector

This block finds where characters begin on a synchronous serial receive stream. One receive bit is presented on `rxd` for each rising edge of `clk`. While hunting, every new bit is shifted into a window register, and after each bit the newest frame-sized slice of that window is compared with a programmed synchronisation character. The detector can require a single character, or a pair of characters that arrive back to back. When the pattern is complete it raises `syndet_out` and moves to a locked state. From then on it cuts the stream into characters on fixed boundaries and presents each one on `char_data` with a one-cycle `char_valid` strobe.

A frame holds the data bits, least significant bit first. With parity enabled, a parity bit follows the data bits. The parity bit fixes the frame length but is never compared. `syndet_out` is a registered output that rises on the rising edge that samples the last bit of the pattern. Bits are launched on falling edges, so that rising edge falls at the middle of the last bit. That last bit is the parity bit when parity is on, and the final data bit when it is off.

In external mode the internal comparison is switched off. `syndet_out` is held low, and a rising level on `syndet_in` marks alignment instead. A status read clears the detect flag. A hunt command drops lock and starts a new search.

Top module: `sync_hunt_det`

## Requirements
- R1: After reset `syndet_out`, `locked` and `char_valid` are all 0.
- R2: The data-bit count of a frame is N = 5 + `char_len`, where `char_len` is 0 to 3. In single-character mode (`dual_sync`=0), `syndet_out` and `locked` go to 1 in the cycle after the rising edge that samples the last bit of a frame matching `sync_char_a`. The match is found at any bit offset in the stream. Bits are sent least significant bit first.
- R3: In two-character mode (`dual_sync`=1), a match on `sync_char_a` alone leaves `syndet_out` at 0. `syndet_out` rises only after a frame matching `sync_char_b` that starts on the very next bit.
- R4: In two-character mode, if the frame after a match on `sync_char_a` differs from `sync_char_b`, no lock occurs and the search resumes bit by bit. A later correct pair then locks.
- R5: With `par_en`=1 each frame carries one parity bit after its data bits. That bit's value is ignored. `syndet_out` rises after the parity bit is sampled, not after the last data bit.
- R6: Only the low N bits of each synchronisation character take part in the comparison. The upper bits have no effect.
- R7: A `status_rd` pulse clears `syndet_out` on the next cycle. A detection in the same cycle takes priority, and `syndet_out` is then 1.
- R8: While locked, `char_valid` pulses once every frame length (N, plus 1 with parity), counted from the lock point. `char_data` then holds the N data bits with the first received bit in bit 0 and zeros above. Bit-level matching stops while locked, so a synchronisation pattern in the data does not set `syndet_out`.
- R9: A `hunt_cmd` pulse clears `syndet_out` and `locked` on the next cycle and restarts the search. The `rxd` bit sampled with the command is discarded.
- R10: With `ext_mode`=1, `syndet_out` stays 0 and internal matches do not lock. A rising edge of `syndet_in` seen on a clock edge sets `locked`. The first data bit is the one sampled on the following edge.
- R11: Once locked in external mode, `syndet_in` may return to 0 and framing continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock, bits sampled on rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive data |
| sync_char_a | input | 8 | First (or only) synchronisation character |
| sync_char_b | input | 8 | Second synchronisation character |
| dual_sync | input | 1 | 1: two-character pattern, 0: one character |
| par_en | input | 1 | 1: a parity bit follows the data bits |
| char_len | input | 2 | Data bits per character minus 5 |
| ext_mode | input | 1 | 1: alignment from syndet_in, internal match off |
| hunt_cmd | input | 1 | One-cycle pulse: drop lock and start a new search |
| status_rd | input | 1 | One-cycle pulse: status read done, clears detect flag |
| syndet_in | input | 1 | External alignment marker (rising edge) |
| syndet_out | output | 1 | Synchronisation detected flag |
| locked | output | 1 | Character boundaries are known |
| char_valid | output | 1 | One-cycle strobe for a framed character |
| char_data | output | 8 | Framed character, zero-extended |

## Verification
The hardest case to reach is the failed second character in two-character mode. The stream must first match `sync_char_a` exactly on a bit boundary. The very next frame must then differ from `sync_char_b`, and a fresh pair must follow. The stimulus must also avoid a false match on `sync_char_a` inside the mixed bits at the joins. The bench sends a hunt command, then character A, then an all-zero frame, then A and B. It checks that nothing locks until the final bit of B. The same-cycle race between a status read and a fresh detection is produced by raising `status_rd` during the last pattern bit.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;
    localparam int unsigned CHAR_W_DEF = 8;
    localparam int unsigned LEN_W_DEF  = 2;
    localparam int unsigned NUM_SYNC   = 2;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_SECOND  = 2'd1,
        ST_LOCKED  = 2'd2,
        ST_EXTWAIT = 2'd3
    } hunt_state_e;
endpackage

// File: rtl/sync_hunt_shift.sv
// Serial window: newest bit enters at bit 0. Exposes the next-state window
// so that a comparison can act on the bit being sampled this edge.
module sync_hunt_shift #(
    parameter int unsigned SH_W  = 9,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             clear,
    output logic [SH_W-1:0]  win_nx,
    output logic [CNT_W-1:0] fill_nx
);
    typedef struct packed {
        logic [SH_W-1:0]  win;
        logic [CNT_W-1:0] fill;
    } shift_t;

    shift_t sh_q, sh_d;

    always_comb begin
        sh_d = sh_q;
        if (clear) begin
            sh_d.win  = '0;
            sh_d.fill = '0;
        end else begin
            sh_d.win = {sh_q.win[SH_W-2:0], bit_in};
            if (sh_q.fill != CNT_W'(SH_W)) begin
                sh_d.fill = sh_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign win_nx  = sh_d.win;
    assign fill_nx = sh_d.fill;
endmodule

// File: rtl/sync_hunt_cmp.sv
// Extracts the data field of the newest frame and compares it with each
// programmed synchronisation character.
module sync_hunt_cmp #(
    parameter int unsigned CHAR_W   = 8,
    parameter int unsigned LEN_W    = 2,
    parameter int unsigned NUM_SYNC = 2,
    parameter int unsigned SH_W     = CHAR_W + 1,
    parameter int unsigned CNT_W    = 4
) (
    input  logic [SH_W-1:0]                 win,
    input  logic [LEN_W-1:0]                char_len,
    input  logic                            par_en,
    input  logic [NUM_SYNC-1:0][CHAR_W-1:0] sync_chars,
    output logic [NUM_SYNC-1:0]             match,
    output logic [CHAR_W-1:0]               frame_data,
    output logic [CNT_W-1:0]                frame_len
);
    localparam int MIN_BITS = int'(CHAR_W) - (2 ** LEN_W) + 1;

    logic [CHAR_W-1:0] mask;

    always_comb begin
        int nbits;
        int flen;
        nbits      = MIN_BITS + int'(char_len);
        flen       = nbits + (par_en ? 1 : 0);
        frame_data = '0;
        mask       = '0;
        for (int i = 0; i < int'(CHAR_W); i++) begin
            if (i < nbits) begin
                mask[i] = 1'b1;
                for (int j = 0; j < int'(SH_W); j++) begin
                    if (j == flen - 1 - i) begin
                        frame_data[i] = win[j];
                    end
                end
            end
        end
        frame_len = CNT_W'(flen);
    end

    for (genvar k = 0; k < NUM_SYNC; k++) begin : g_cmp
        assign match[k] = ((sync_chars[k] & mask) == frame_data);
    end
endmodule

// File: rtl/sync_hunt_fsm.sv
// Hunt / second-character / locked / external-wait sequencing, boundary
// counter and detect flag.
module sync_hunt_fsm
    import sync_hunt_pkg::*;
#(
    parameter int unsigned CHAR_W = 8,
    parameter int unsigned CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hunt_cmd,
    input  logic              ext_mode,
    input  logic              dual_sync,
    input  logic              status_rd,
    input  logic              syndet_in,
    input  logic              match_a,
    input  logic              match_b,
    input  logic [CNT_W-1:0]  fill_nx,
    input  logic [CNT_W-1:0]  frame_len,
    input  logic [CHAR_W-1:0] frame_data,
    output logic              syndet_flag,
    output logic              locked,
    output logic              char_valid,
    output logic [CHAR_W-1:0] char_data
);
    typedef struct packed {
        hunt_state_e       state;
        logic [CNT_W-1:0]  cnt;
        logic              syndet;
        logic              ext_prev;
        logic              valid;
        logic [CHAR_W-1:0] data;
    } fsm_t;

    fsm_t st_q, st_d;

    always_comb begin
        logic             det_set;
        logic [CNT_W-1:0] cnt_n;
        logic             full;
        st_d          = st_q;
        st_d.valid    = 1'b0;
        st_d.ext_prev = syndet_in;
        det_set       = 1'b0;
        cnt_n         = st_q.cnt + 1'b1;
        full          = (fill_nx >= frame_len);

        if (hunt_cmd) begin
            st_d.state = ext_mode ? ST_EXTWAIT : ST_HUNT;
            st_d.cnt   = '0;
        end else begin
            unique case (st_q.state)
                ST_HUNT: begin
                    if (ext_mode) begin
                        st_d.state = ST_EXTWAIT;
                    end else if (full && match_a) begin
                        st_d.cnt = '0;
                        if (dual_sync) begin
                            st_d.state = ST_SECOND;
                        end else begin
                            st_d.state = ST_LOCKED;
                            det_set    = 1'b1;
                        end
                    end
                end
                ST_SECOND: begin
                    if (ext_mode) begin
                        st_d.state = ST_EXTWAIT;
                    end else if (cnt_n == frame_len) begin
                        st_d.cnt = '0;
                        if (match_b) begin
                            st_d.state = ST_LOCKED;
                            det_set    = 1'b1;
                        end else if (!match_a) begin
                            st_d.state = ST_HUNT;
                        end
                    end else begin
                        st_d.cnt = cnt_n;
                    end
                end
                ST_LOCKED: begin
                    if (cnt_n == frame_len) begin
                        st_d.cnt   = '0;
                        st_d.valid = 1'b1;
                        st_d.data  = frame_data;
                    end else begin
                        st_d.cnt = cnt_n;
                    end
                end
                ST_EXTWAIT: begin
                    if (!ext_mode) begin
                        st_d.state = ST_HUNT;
                    end else if (syndet_in && !st_q.ext_prev) begin
                        st_d.state = ST_LOCKED;
                        st_d.cnt   = '0;
                    end
                end
                default: st_d.state = ST_HUNT;
            endcase
        end

        if (hunt_cmd) begin
            st_d.syndet = 1'b0;
        end else if (det_set) begin
            st_d.syndet = 1'b1;
        end else if (status_rd) begin
            st_d.syndet = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.state    <= ST_HUNT;
            st_q.ext_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign syndet_flag = st_q.syndet;
    assign locked      = (st_q.state == ST_LOCKED);
    assign char_valid  = st_q.valid;
    assign char_data   = st_q.data;
endmodule

// File: rtl/sync_hunt_det.sv
module sync_hunt_det
    import sync_hunt_pkg::*;
#(
    parameter int unsigned CHAR_W = CHAR_W_DEF,
    parameter int unsigned LEN_W  = LEN_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic [CHAR_W-1:0] sync_char_a,
    input  logic [CHAR_W-1:0] sync_char_b,
    input  logic              dual_sync,
    input  logic              par_en,
    input  logic [LEN_W-1:0]  char_len,
    input  logic              ext_mode,
    input  logic              hunt_cmd,
    input  logic              status_rd,
    input  logic              syndet_in,
    output logic              syndet_out,
    output logic              locked,
    output logic              char_valid,
    output logic [CHAR_W-1:0] char_data
);
    localparam int unsigned SH_W  = CHAR_W + 1;
    localparam int unsigned CNT_W = $clog2(SH_W + 1);

    logic [SH_W-1:0]                 win_nx;
    logic [CNT_W-1:0]                fill_nx;
    logic [CNT_W-1:0]                frame_len;
    logic [CHAR_W-1:0]               frame_data;
    logic [NUM_SYNC-1:0]             match;
    logic [NUM_SYNC-1:0][CHAR_W-1:0] sync_chars;
    logic                            syndet_flag;

    assign sync_chars[0] = sync_char_a;
    assign sync_chars[1] = sync_char_b;

    sync_hunt_shift #(.SH_W(SH_W), .CNT_W(CNT_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (rxd),
        .clear   (hunt_cmd),
        .win_nx  (win_nx),
        .fill_nx (fill_nx)
    );

    sync_hunt_cmp #(
        .CHAR_W(CHAR_W), .LEN_W(LEN_W), .NUM_SYNC(NUM_SYNC),
        .SH_W(SH_W), .CNT_W(CNT_W)
    ) u_cmp (
        .win        (win_nx),
        .char_len   (char_len),
        .par_en     (par_en),
        .sync_chars (sync_chars),
        .match      (match),
        .frame_data (frame_data),
        .frame_len  (frame_len)
    );

    sync_hunt_fsm #(.CHAR_W(CHAR_W), .CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hunt_cmd    (hunt_cmd),
        .ext_mode    (ext_mode),
        .dual_sync   (dual_sync),
        .status_rd   (status_rd),
        .syndet_in   (syndet_in),
        .match_a     (match[0]),
        .match_b     (match[1]),
        .fill_nx     (fill_nx),
        .frame_len   (frame_len),
        .frame_data  (frame_data),
        .syndet_flag (syndet_flag),
        .locked      (locked),
        .char_valid  (char_valid),
        .char_data   (char_data)
    );

    assign syndet_out = syndet_flag & ~ext_mode;
endmodule

// File: rtl/sync_hunt_chk.sv
module sync_hunt_chk (
    input logic clk,
    input logic rst_n,
    input logic ext_mode,
    input logic hunt_cmd,
    input logic status_rd,
    input logic syndet_in,
    input logic syndet_out,
    input logic locked,
    input logic char_valid
);
    // R2: a fresh internal detection comes with lock
    p_detect_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(syndet_out) && !$past(ext_mode) |-> locked);

    // R7: a status read clears an existing detect flag
    p_status_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        syndet_out && status_rd |=> !syndet_out);

    // R7: the detect flag holds without a read or hunt
    p_flag_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        syndet_out && !status_rd && !hunt_cmd && !ext_mode |=> syndet_out || ext_mode);

    // R8: characters only appear out of the locked state, never back to back
    p_valid_from_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> $past(locked));
    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);

    // R9: a hunt command drops lock and detect flag
    p_hunt_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_cmd |=> !locked && !syndet_out);

    // R10: in external mode lock follows only the external marker
    p_ext_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) && $past(ext_mode) |-> $past(syndet_in));
endmodule

bind sync_hunt_det sync_hunt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_mode   (ext_mode),
    .hunt_cmd   (hunt_cmd),
    .status_rd  (status_rd),
    .syndet_in  (syndet_in),
    .syndet_out (syndet_out),
    .locked     (locked),
    .char_valid (char_valid)
);

// File: tb/sync_hunt_det_bench.sv
module sync_hunt_det_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [7:0] sync_char_a = 8'h16;
    logic [7:0] sync_char_b = 8'h3C;
    logic       dual_sync = 1'b0;
    logic       par_en = 1'b0;
    logic [1:0] char_len = 2'd3;
    logic       ext_mode = 1'b0;
    logic       hunt_cmd = 1'b0;
    logic       status_rd = 1'b0;
    logic       syndet_in = 1'b0;
    logic       syndet_out;
    logic       locked;
    logic       char_valid;
    logic [7:0] char_data;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P / 2) clk = ~clk;

    sync_hunt_det u_sync_hunt_det (
        .clk(clk), .rst_n(rst_n), .rxd(rxd),
        .sync_char_a(sync_char_a), .sync_char_b(sync_char_b),
        .dual_sync(dual_sync), .par_en(par_en), .char_len(char_len),
        .ext_mode(ext_mode), .hunt_cmd(hunt_cmd), .status_rd(status_rd),
        .syndet_in(syndet_in), .syndet_out(syndet_out), .locked(locked),
        .char_valid(char_valid), .char_data(char_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic send_bit(input logic b);
        rxd = b;
        @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] c, input int from, input int upto);
        for (int i = from; i < upto; i++) send_bit(c[i]);
    endtask

    task automatic do_hunt();
        hunt_cmd = 1'b1;
        rxd      = 1'b1;
        @(negedge clk);
        hunt_cmd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 syndet", syndet_out, 0);
        chk("R1 locked", locked, 0);
        chk("R1 valid", char_valid, 0);
    endtask

    task automatic t_single();
        do_hunt();
        send_bit(1); send_bit(0); send_bit(1);
        send_bits(8'h16, 0, 7);
        chk("R2 before last bit", syndet_out, 0);
        send_bits(8'h16, 7, 8);
        chk("R2 syndet", syndet_out, 1);
        chk("R2 locked", locked, 1);
    endtask

    task automatic t_frame();
        send_bits(8'h5A, 0, 7);
        chk("R8 no early valid", char_valid, 0);
        send_bits(8'h5A, 7, 8);
        chk("R8 valid", char_valid, 1);
        chk("R8 data", char_data, 8'h5A);
        status_rd = 1'b1;
        send_bits(8'h16, 0, 1);
        status_rd = 1'b0;
        chk("R7 cleared", syndet_out, 0);
        send_bits(8'h16, 1, 8);
        chk("R8 sync as data valid", char_valid, 1);
        chk("R8 sync as data value", char_data, 8'h16);
        chk("R8 no re-detect", syndet_out, 0);
    endtask

    task automatic t_hunt();
        do_hunt();
        chk("R9 locked", locked, 0);
        chk("R9 syndet", syndet_out, 0);
    endtask

    task automatic t_dual();
        dual_sync = 1'b1;
        do_hunt();
        send_bits(8'h16, 0, 8);
        chk("R3 first only", syndet_out, 0);
        chk("R3 first only lock", locked, 0);
        send_bits(8'h3C, 0, 7);
        chk("R3 before last", syndet_out, 0);
        send_bits(8'h3C, 7, 8);
        chk("R3 syndet", syndet_out, 1);
    endtask

    task automatic t_dual_miss();
        do_hunt();
        send_bits(8'h16, 0, 8);
        send_bits(8'h00, 0, 8);
        chk("R4 no lock", locked, 0);
        chk("R4 no syndet", syndet_out, 0);
        send_bits(8'h16, 0, 8);
        chk("R4 retry first", syndet_out, 0);
        send_bits(8'h3C, 0, 8);
        chk("R4 retry pair", syndet_out, 1);
        dual_sync = 1'b0;
    endtask

    task automatic t_par_len();
        par_en      = 1'b1;
        char_len    = 2'd0;
        sync_char_a = 8'hF5;
        do_hunt();
        send_bit(1); send_bit(1);
        send_bits(8'h15, 0, 5);
        chk("R5 not at data end", syndet_out, 0);
        send_bit(1);
        chk("R5 R6 syndet after parity", syndet_out, 1);
        send_bits(8'h0B, 0, 5);
        chk("R8 short no valid", char_valid, 0);
        send_bit(0);
        chk("R8 short valid", char_valid, 1);
        chk("R8 short data", char_data, 8'h0B);
        par_en      = 1'b0;
        char_len    = 2'd3;
        sync_char_a = 8'h16;
    endtask

    task automatic t_setwin();
        do_hunt();
        send_bits(8'h16, 0, 7);
        status_rd = 1'b1;
        send_bits(8'h16, 7, 8);
        status_rd = 1'b0;
        chk("R7 set wins", syndet_out, 1);
    endtask

    task automatic t_ext();
        ext_mode = 1'b1;
        do_hunt();
        send_bits(8'h16, 0, 8);
        chk("R10 no internal lock", locked, 0);
        chk("R10 syndet low", syndet_out, 0);
        syndet_in = 1'b1;
        send_bit(1);
        chk("R10 ext lock", locked, 1);
        syndet_in = 1'b0;
        send_bits(8'hC3, 0, 7);
        chk("R11 no early valid", char_valid, 0);
        send_bits(8'hC3, 7, 8);
        chk("R11 valid", char_valid, 1);
        chk("R11 data", char_data, 8'hC3);
        chk("R10 syndet still low", syndet_out, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single();
        t_frame();
        t_hunt();
        t_dual();
        t_dual_miss();
        t_par_len();
        t_setwin();
        t_ext();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule